// File: doc/BRIEF.md
# Parallel Port Host Handshake Controller

This block is the host end of an Enhanced Parallel Port link. Software starts a transfer with a single register write. The block then runs the whole handshake on the active-low port lines without further help. The lines it drives are a direction line, a data strobe and an address strobe. It paces each transfer by the peripheral's wait input, not by a host timer. The 8-bit shared address/data bus is presented as separate output, output-enable and input signals, so the pad buffers stay outside the block.

Four transfer kinds exist: data write, address write, data read and address read. The direction line tells writes from reads. Which strobe is pulsed tells data from address traffic. The wait and interrupt inputs pass through two-flop synchronizers. A programmable watchdog counter abandons a transfer whose wait line never rises and records the event in a sticky status bit. The block also drives an active-low peripheral reset line and reports the active-low interrupt request.

Top module: `pp_host`

## Requirements
- R1: After reset both strobes and the direction line are high, the bus output enable is 0, the peripheral reset output is high, the status register (offset 2) reads 0 and the limit register (offset 1) reads 100.
- R2: A CPU write to offset 4 starts a data write. The direction line goes low and the written byte is driven with output enable 1 for at least one cycle before the data strobe goes low. The address strobe stays high.
- R3: A CPU write to offset 3 starts an address write with the written byte. Only the address strobe is pulsed, and the direction line is low.
- R4: Writing offset 0 with bit 0 set starts a data read, and with only bit 1 set it starts an address read (bit 0 has priority). During a read the direction line stays high and output enable stays 0.
- R5: The active strobe stays low until the synchronized wait input is seen high. It then returns high, with the direction line, within 4 clocks of wait rising. A read latches the bus in that cycle, and the byte reads back at offset 4.
- R6: A transfer begins only when the synchronized wait input is low. While wait is high, a request stays pending with status bit 0 (busy) at 1 and no strobe.
- R7: After a strobe is released, busy stays 1 and no new strobe occurs until wait has returned low.
- R8: Start writes (offsets 3, 4, or 0 with bit 0 or 1) issued while busy is 1 are ignored.
- R9: If wait does not rise, the strobe is released after at most limit+1 clocks low. The lines go inactive, busy clears and status bit 1 (timeout) is set. It stays set until a write to offset 0 with bit 3 set.
- R10: Offset 0 bit 2 is a level: while it is 1 the peripheral reset output is low, and it reads back at bit 2. Status bit 2 is 1 while the synchronized interrupt input is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 3 | Register offset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data, one clock after the address |
| pp_dir | output | 1 | Direction: low for write, high for read |
| pp_dstb_n | output | 1 | Data strobe, active low |
| pp_astb_n | output | 1 | Address strobe, active low |
| pp_ad_o | output | 8 | Bus value driven by the host |
| pp_ad_oe | output | 1 | Bus output enable |
| pp_ad_i | input | 8 | Bus value seen at the pads |
| pp_wait | input | 1 | Peripheral wait (low: may start, high: may end) |
| pp_irq_n | input | 1 | Peripheral interrupt request, active low |
| pp_rst_n | output | 1 | Peripheral reset, active low |

## Verification
The hardest state to reach is a request that must wait on the start gate. That is a start issued while the wait line is already high, before any strobe, and it never occurs with a well-behaved peripheral. The bench's peripheral model can be disabled and the wait line held high by hand before the write. The bench then checks for many cycles that no strobe moves and busy stays set, and only afterwards releases the line. A peripheral that keeps wait high long after the strobe is released is set up the same way. This tests the end-of-cycle hold-off.

// File: rtl/pp_host_pkg.sv
package pp_host_pkg;
  typedef enum logic [1:0] {K_DWR, K_AWR, K_DRD, K_ARD} xfer_kind_e;
  typedef enum logic [2:0] {S_IDLE, S_ARM, S_SETUP, S_STROBE, S_RELEASE} seq_state_e;
  localparam int unsigned OFS_CTRL  = 0;
  localparam int unsigned OFS_LIMIT = 1;
  localparam int unsigned OFS_STAT  = 2;
  localparam int unsigned OFS_ADDR  = 3;
  localparam int unsigned OFS_DATA  = 4;
endpackage

// File: rtl/pp_host_sync.sv
module pp_host_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pp_host_regs.sv
module pp_host_regs
  import pp_host_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned AW      = 3,
  parameter int unsigned TO_INIT = 100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          seq_busy,
  input  logic          wait_s,
  input  logic          irq_n_s,
  input  logic          to_hit,
  input  logic [DW-1:0] rd_byte,
  output logic          req,
  output xfer_kind_e    req_kind,
  output logic [DW-1:0] req_data,
  output logic [DW-1:0] limit,
  output logic          prst_n
);
  localparam logic [AW-1:0] A_CTRL  = AW'(OFS_CTRL);
  localparam logic [AW-1:0] A_LIMIT = AW'(OFS_LIMIT);
  localparam logic [AW-1:0] A_STAT  = AW'(OFS_STAT);
  localparam logic [AW-1:0] A_ADDR  = AW'(OFS_ADDR);
  localparam logic [AW-1:0] A_DATA  = AW'(OFS_DATA);

  logic prst_bit, sticky, busy_any;
  assign busy_any = seq_busy | req;

  always_ff @(posedge clk) begin
    if (rst) begin
      limit    <= DW'(TO_INIT);
      prst_bit <= 1'b0;
      prst_n   <= 1'b1;
      sticky   <= 1'b0;
      req      <= 1'b0;
      req_kind <= K_DWR;
      req_data <= '0;
    end else begin
      req <= 1'b0;
      if (cpu_wr) begin
        unique case (cpu_addr)
          A_CTRL: begin
            prst_bit <= cpu_wdata[2];
            prst_n   <= ~cpu_wdata[2];
            if (cpu_wdata[3]) sticky <= 1'b0;
            if (!busy_any && (cpu_wdata[0] || cpu_wdata[1])) begin
              req      <= 1'b1;
              req_kind <= cpu_wdata[0] ? K_DRD : K_ARD;
            end
          end
          A_LIMIT: limit <= cpu_wdata;
          A_ADDR, A_DATA: begin
            if (!busy_any) begin
              req      <= 1'b1;
              req_kind <= (cpu_addr == A_ADDR) ? K_AWR : K_DWR;
              req_data <= cpu_wdata;
            end
          end
          default: ;
        endcase
      end
      if (to_hit) sticky <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cpu_rdata <= '0;
    else begin
      unique case (cpu_addr)
        A_CTRL:  cpu_rdata <= {{(DW-3){1'b0}}, prst_bit, 2'b00};
        A_LIMIT: cpu_rdata <= limit;
        A_STAT:  cpu_rdata <= {{(DW-4){1'b0}}, wait_s, ~irq_n_s, sticky, busy_any};
        A_DATA:  cpu_rdata <= rd_byte;
        default: cpu_rdata <= '0;
      endcase
    end
  end

  // R9: a timeout event always leaves the sticky bit set
  p_sticky_set_r9: assert property (@(posedge clk) disable iff (rst)
    to_hit |=> sticky);
  // R10: reset output follows the control level
  p_prst_level_r10: assert property (@(posedge clk) disable iff (rst)
    prst_n == ~prst_bit);
endmodule

// File: rtl/pp_host_seq.sv
module pp_host_seq
  import pp_host_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  xfer_kind_e    req_kind,
  input  logic [DW-1:0] req_data,
  input  logic [DW-1:0] limit,
  input  logic          wait_s,
  input  logic [DW-1:0] ad_in,
  output logic          busy,
  output logic          to_hit,
  output logic [DW-1:0] rd_byte,
  output logic          dir_q,
  output logic          dstb_q,
  output logic          astb_q,
  output logic [DW-1:0] ad_q,
  output logic          oe_q
);
  seq_state_e st, nx;
  xfer_kind_e kind_q;
  logic [DW-1:0] wbyte_q, cnt;
  logic is_rd, is_addr, drive;

  assign is_rd   = (kind_q == K_DRD) || (kind_q == K_ARD);
  assign is_addr = (kind_q == K_AWR) || (kind_q == K_ARD);
  assign to_hit  = (st == S_STROBE) && !wait_s && (cnt == limit);
  assign busy    = (st != S_IDLE);
  assign drive   = (nx == S_SETUP) || (nx == S_STROBE);

  always_comb begin
    nx = st;
    unique case (st)
      S_IDLE:    if (req) nx = S_ARM;
      S_ARM:     if (!wait_s) nx = S_SETUP;
      S_SETUP:   nx = S_STROBE;
      S_STROBE:  if (wait_s || to_hit) nx = S_RELEASE;
      S_RELEASE: if (!wait_s) nx = S_IDLE;
      default:   nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      kind_q  <= K_DWR;
      wbyte_q <= '0;
      cnt     <= '0;
      rd_byte <= '0;
    end else begin
      st <= nx;
      if (st == S_IDLE && req) begin
        kind_q  <= req_kind;
        wbyte_q <= req_data;
      end
      if (st != S_STROBE) cnt <= '0;
      else if (cnt != limit) cnt <= cnt + 1'b1;
      if (st == S_STROBE && wait_s && is_rd) rd_byte <= ad_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= 1'b1;
      oe_q   <= 1'b0;
      ad_q   <= '0;
      dstb_q <= 1'b1;
      astb_q <= 1'b1;
    end else begin
      dir_q  <= !(drive && !is_rd);
      oe_q   <= drive && !is_rd;
      if (nx == S_SETUP) ad_q <= wbyte_q;
      dstb_q <= !(nx == S_STROBE && !is_addr);
      astb_q <= !(nx == S_STROBE && is_addr);
    end
  end

  // R2: never both strobes low
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    !(!dstb_q && !astb_q));
  // R2: direction and enable are settled before a strobe falls
  p_dir_setup_r2: assert property (@(posedge clk) disable iff (rst)
    ($fell(dstb_q) || $fell(astb_q)) |-> ($stable(dir_q) && $stable(oe_q)));
  // R4: the bus is only driven in the write direction
  p_drive_write_r4: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> !dir_q);
  // R5: wait seen high ends the strobe in the next cycle
  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    (st == S_STROBE && wait_s) |=> (dstb_q && astb_q && dir_q && !oe_q));
  // R6: no start while wait is high
  p_start_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (st == S_ARM && wait_s) |=> (st == S_ARM && dstb_q && astb_q));
  // R7: hold-off until wait returns low
  p_holdoff_r7: assert property (@(posedge clk) disable iff (rst)
    (st == S_RELEASE && wait_s) |=> (st == S_RELEASE));
  // R8: requests during a transfer do not alter it
  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (st != S_IDLE) |=> ($stable(wbyte_q) && $stable(kind_q)));
endmodule

// File: rtl/pp_host.sv
module pp_host
  import pp_host_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned AW          = 3,
  parameter int unsigned TO_INIT     = 100,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          pp_dir,
  output logic          pp_dstb_n,
  output logic          pp_astb_n,
  output logic [DW-1:0] pp_ad_o,
  output logic          pp_ad_oe,
  input  logic [DW-1:0] pp_ad_i,
  input  logic          pp_wait,
  input  logic          pp_irq_n,
  output logic          pp_rst_n
);
  logic [1:0] sync_q;
  logic wait_s, irq_n_s, seq_busy, to_hit, req;
  xfer_kind_e req_kind;
  logic [DW-1:0] req_data, limit, rd_byte;

  pp_host_sync #(.W(2), .STAGES(SYNC_STAGES), .INIT(2'b10)) u_sync (
    .clk(clk), .rst(rst), .d({pp_irq_n, pp_wait}), .q(sync_q));
  assign wait_s  = sync_q[0];
  assign irq_n_s = sync_q[1];

  pp_host_regs #(.DW(DW), .AW(AW), .TO_INIT(TO_INIT)) u_regs (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .seq_busy(seq_busy),
    .wait_s(wait_s), .irq_n_s(irq_n_s), .to_hit(to_hit), .rd_byte(rd_byte),
    .req(req), .req_kind(req_kind), .req_data(req_data), .limit(limit),
    .prst_n(pp_rst_n));

  pp_host_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst(rst), .req(req), .req_kind(req_kind), .req_data(req_data),
    .limit(limit), .wait_s(wait_s), .ad_in(pp_ad_i), .busy(seq_busy),
    .to_hit(to_hit), .rd_byte(rd_byte), .dir_q(pp_dir), .dstb_q(pp_dstb_n),
    .astb_q(pp_astb_n), .ad_q(pp_ad_o), .oe_q(pp_ad_oe));
endmodule

// File: tb/pp_host_bench.sv
module pp_host_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] cpu_addr = '0;
  logic cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic pp_dir, pp_dstb_n, pp_astb_n, pp_ad_oe, pp_rst_n;
  logic [7:0] pp_ad_o;
  logic [7:0] ad_in = 8'hFF;
  logic wait_line = 1'b0;
  logic irq_line = 1'b1;

  always #4 clk = ~clk;

  pp_host u_pp_host (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .pp_dir(pp_dir),
    .pp_dstb_n(pp_dstb_n), .pp_astb_n(pp_astb_n), .pp_ad_o(pp_ad_o),
    .pp_ad_oe(pp_ad_oe), .pp_ad_i(ad_in), .pp_wait(wait_line),
    .pp_irq_n(irq_line), .pp_rst_n(pp_rst_n));

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // peripheral model
  bit resp_en = 0;
  int resp_delay = 2, resp_hold = 0;
  logic [7:0] resp_data = 8'h00;
  int n_cyc = 0, rel_lat = 0;
  bit rec_astb, rec_dir, rec_oe, rec_pre_dir, rec_pre_oe, rec_early, rec_violate;
  logic [7:0] rec_ad, rec_pre_ad;
  bit last_dir = 1, last_oe = 0;
  logic [7:0] last_ad = '0;
  int strobe_lows = 0;

  always @(negedge clk) if (!pp_dstb_n || !pp_astb_n) strobe_lows++;

  always begin
    @(negedge clk);
    if (resp_en && (!pp_dstb_n || !pp_astb_n)) begin
      rec_astb = !pp_astb_n; rec_dir = pp_dir; rec_oe = pp_ad_oe; rec_ad = pp_ad_o;
      rec_pre_dir = last_dir; rec_pre_oe = last_oe; rec_pre_ad = last_ad;
      rec_early = 0; rec_violate = 0;
      for (int i = 0; i < resp_delay; i++) begin
        @(negedge clk);
        if (pp_dstb_n && pp_astb_n) rec_early = 1;
        if (pp_ad_oe != rec_oe) rec_early = 1;
      end
      ad_in = resp_data;
      wait_line = 1'b1;
      rel_lat = 0;
      while (!pp_dstb_n || !pp_astb_n) begin
        @(negedge clk);
        rel_lat++;
      end
      ad_in = 8'hFF;
      for (int i = 0; i < resp_hold; i++) begin
        @(negedge clk);
        if (!pp_dstb_n || !pp_astb_n) rec_violate = 1;
      end
      wait_line = 1'b0;
      n_cyc++;
    end
    last_dir = pp_dir; last_oe = pp_ad_oe; last_ad = pp_ad_o;
  end

  task automatic cpu_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wr = 1'b0;
    @(negedge clk);
    d = cpu_rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [7:0] s;
    for (int i = 0; i < 400; i++) begin
      cpu_read(3'd2, s);
      if (!s[0]) return;
    end
    check(0, tag, 1, 0);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check(pp_dstb_n && pp_astb_n, "R1 strobes idle", {pp_dstb_n, pp_astb_n}, 3);
    check(pp_dir == 1 && pp_ad_oe == 0, "R1 dir/oe", {pp_dir, pp_ad_oe}, 2);
    check(pp_rst_n == 1, "R1 reset out", pp_rst_n, 1);
    cpu_read(3'd2, v); check(v == 8'h00, "R1 status", v, 0);
    cpu_read(3'd1, v); check(v == 8'd100, "R1 limit", v, 100);
  endtask

  task automatic t_data_write;
    int c0 = n_cyc;
    resp_en = 1; resp_delay = 3; resp_hold = 0;
    cpu_write(3'd4, 8'hA5);
    wait_idle("R2 busy stuck");
    check(n_cyc == c0 + 1, "R2 one cycle", n_cyc - c0, 1);
    check(rec_pre_dir == 0 && rec_pre_oe == 1 && rec_pre_ad == 8'hA5, "R2 setup before strobe",
          {rec_pre_dir, rec_pre_oe}, 1);
    check(rec_ad == 8'hA5 && rec_oe == 1 && rec_dir == 0, "R2 byte driven", rec_ad, 8'hA5);
    check(rec_astb == 0, "R2 data strobe used", rec_astb, 0);
    check(rec_early == 0, "R5 held until wait", rec_early, 0);
    check(rel_lat >= 1 && rel_lat <= 4, "R5 release latency", rel_lat, 3);
    check(pp_dir == 1 && pp_ad_oe == 0, "R5 lines idle after", {pp_dir, pp_ad_oe}, 2);
  endtask

  task automatic t_addr_write;
    int c0 = n_cyc;
    resp_en = 1; resp_delay = 1;
    cpu_write(3'd3, 8'h3C);
    wait_idle("R3 busy stuck");
    check(n_cyc == c0 + 1, "R3 one cycle", n_cyc - c0, 1);
    check(rec_astb == 1 && rec_ad == 8'h3C && rec_dir == 0, "R3 address strobe", rec_ad, 8'h3C);
  endtask

  task automatic t_reads;
    logic [7:0] v;
    resp_en = 1; resp_delay = 4; resp_data = 8'h5A;
    cpu_write(3'd0, 8'h01);
    wait_idle("R4 busy stuck");
    check(rec_astb == 0 && rec_dir == 1 && rec_oe == 0 && rec_pre_oe == 0, "R4 data read lines",
          {rec_astb, rec_dir, rec_oe}, 2);
    cpu_read(3'd4, v); check(v == 8'h5A, "R5 data read byte", v, 8'h5A);
    resp_data = 8'hC3;
    cpu_write(3'd0, 8'h02);
    wait_idle("R4 busy stuck");
    check(rec_astb == 1 && rec_dir == 1 && rec_oe == 0, "R4 address read lines",
          {rec_astb, rec_dir, rec_oe}, 6);
    cpu_read(3'd4, v); check(v == 8'hC3, "R5 address read byte", v, 8'hC3);
    resp_data = 8'h96;
    cpu_write(3'd0, 8'h03);
    wait_idle("R4 busy stuck");
    check(rec_astb == 0, "R4 bit0 priority", rec_astb, 0);
  endtask

  task automatic t_start_gate;
    logic [7:0] v;
    int c0 = n_cyc;
    bit moved = 0;
    resp_en = 0; wait_line = 1'b1;
    repeat (4) @(negedge clk);
    cpu_write(3'd4, 8'h77);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!pp_dstb_n || !pp_astb_n) moved = 1;
    end
    check(moved == 0, "R6 no strobe while wait high", moved, 0);
    cpu_read(3'd2, v); check(v[0] == 1, "R6 pending busy", v[0], 1);
    resp_en = 1; resp_delay = 2; wait_line = 1'b0;
    wait_idle("R6 busy stuck");
    check(n_cyc == c0 + 1 && rec_ad == 8'h77, "R6 started after wait low", rec_ad, 8'h77);
  endtask

  task automatic t_holdoff;
    logic [7:0] v;
    resp_en = 1; resp_delay = 2; resp_hold = 20;
    cpu_write(3'd4, 8'h42);
    while (pp_dstb_n) @(negedge clk);
    while (!pp_dstb_n) @(negedge clk);
    repeat (3) @(negedge clk);
    cpu_read(3'd2, v); check(v[0] == 1, "R7 busy during hold", v[0], 1);
    wait_idle("R7 busy stuck");
    check(rec_violate == 0, "R7 no strobe during hold", rec_violate, 0);
    resp_hold = 0;
  endtask

  task automatic t_ignore_busy;
    int c0 = n_cyc;
    resp_en = 1; resp_delay = 15;
    cpu_write(3'd4, 8'h11);
    repeat (6) @(negedge clk);
    cpu_write(3'd4, 8'h22);
    cpu_write(3'd3, 8'h33);
    cpu_write(3'd0, 8'h01);
    wait_idle("R8 busy stuck");
    repeat (12) @(negedge clk);
    check(n_cyc == c0 + 1, "R8 extra starts ignored", n_cyc - c0, 1);
    check(rec_ad == 8'h11 && rec_astb == 0, "R8 first byte kept", rec_ad, 8'h11);
    resp_delay = 2;
  endtask

  task automatic t_timeout;
    logic [7:0] v;
    int s0;
    resp_en = 0; wait_line = 1'b0;
    cpu_write(3'd1, 8'd10);
    s0 = strobe_lows;
    cpu_write(3'd4, 8'hEE);
    repeat (40) @(negedge clk);
    check(strobe_lows - s0 >= 10 && strobe_lows - s0 <= 11, "R9 strobe low length",
          strobe_lows - s0, 10);
    check(pp_dstb_n && pp_astb_n && pp_dir && !pp_ad_oe, "R9 lines inactive",
          {pp_dstb_n, pp_astb_n, pp_dir, pp_ad_oe}, 14);
    cpu_read(3'd2, v); check(v[1:0] == 2'b10, "R9 sticky set busy clear", v[1:0], 2);
    cpu_write(3'd0, 8'h00);
    cpu_read(3'd2, v); check(v[1] == 1, "R9 sticky holds", v[1], 1);
    cpu_write(3'd0, 8'h08);
    cpu_read(3'd2, v); check(v[1] == 0, "R9 sticky cleared", v[1], 0);
    cpu_write(3'd1, 8'd100);
  endtask

  task automatic t_side;
    logic [7:0] v;
    cpu_write(3'd0, 8'h04);
    @(negedge clk);
    check(pp_rst_n == 0, "R10 reset asserted", pp_rst_n, 0);
    cpu_read(3'd0, v); check(v[2] == 1, "R10 reset readback", v[2], 1);
    cpu_write(3'd0, 8'h00);
    @(negedge clk);
    check(pp_rst_n == 1, "R10 reset released", pp_rst_n, 1);
    irq_line = 1'b0;
    repeat (4) @(negedge clk);
    cpu_read(3'd2, v); check(v[2] == 1, "R10 irq seen", v[2], 1);
    irq_line = 1'b1;
    repeat (4) @(negedge clk);
    cpu_read(3'd2, v); check(v[2] == 0, "R10 irq gone", v[2], 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_data_write();
    t_addr_write();
    t_reads();
    t_start_gate();
    t_holdoff();
    t_ignore_busy();
    t_timeout();
    t_side();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule